// File: doc/BRIEF.md
# DMA Channel Request and Interrupt Controller

This block sits between a set of peripherals, a DMA transfer engine and the interrupt controller. For each of `NUM_CH` channels it keeps an enable bit and a request-mask bit. Software changes both through write-one-to-set and write-one-to-clear strobes. It qualifies the single and burst requests that peripherals raise, and it accepts software request strobes for any channel. Each cycle it issues at most one registered start pulse to the engine, together with the channel index and a burst flag.

The highest channel, `NUM_CH-1`, is reserved for software-initiated transfers. Completion is signalled by the engine through a per-channel done strobe. The done strobe latches a pending interrupt on the vector that belongs to that channel, whatever started the transfer. The software channel's vector is the software interrupt. A handler-entry acknowledge strobe for a vector clears its pending bit.

While a peripheral channel is enabled, the normal interrupt line of that peripheral is held off its vector. Only the completion event can then reach the processor.

Top module: `dma_req_irq_ctrl`

## Requirements
- R1: After reset every channel is disabled and unmasked, no software request is pending, no start is issued and no completion is pending. `irq_o[c]` then equals `periph_irq_i[c]` for every c below `NUM_CH-1`, and `irq_o[NUM_CH-1]` is 0.
- R2: `en_set_i[c]`=1 sets the enable bit of channel c and `en_clr_i[c]`=1 clears it; clear wins if both are 1. A disabled channel is never started.
- R3: `mask_set_i[c]`=1 sets the mask bit of c and `mask_clr_i[c]`=1 clears it; set wins if both are 1. While the bit is set, the hardware requests of c are ignored.
- R4: `sw_req_i[c]`=1 makes a request pending on any channel c, masked or not. The request stays pending until c is started and is then cleared, so it causes exactly one start.
- R5: A start is issued in the cycle after channel c is enabled, not active, and has a pending software request or an unmasked hardware request. `start_burst_o` is 1 exactly when an unmasked `hw_burst_i[c]` was present; a burst request takes precedence over a single request.
- R6: When several channels are ready in one cycle, the lowest index is started first, one start per cycle.
- R7: A started channel is active and is not started again until its `done_i` strobe arrives.
- R8: `done_i[c]` sets the pending interrupt of vector c, visible on `irq_o[c]` in the next cycle. A software-triggered peripheral channel reports on its own vector and not on vector `NUM_CH-1`.
- R9: `irq_ack_i[c]` clears the pending interrupt of vector c in the next cycle; a `done_i[c]` in the same cycle wins.
- R10: For a peripheral channel c, `irq_o[c]` is the pending bit OR (`periph_irq_i[c]` AND NOT enable[c]). `periph_irq_i[NUM_CH-1]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_set_i | input | NUM_CH | Write-one-to-set of channel enables |
| en_clr_i | input | NUM_CH | Write-one-to-clear of channel enables |
| mask_set_i | input | NUM_CH | Write-one-to-set of request masks |
| mask_clr_i | input | NUM_CH | Write-one-to-clear of request masks |
| sw_req_i | input | NUM_CH | Software request strobes |
| hw_single_i | input | NUM_CH | Peripheral single requests |
| hw_burst_i | input | NUM_CH | Peripheral burst requests |
| done_i | input | NUM_CH | Per-channel completion strobes from the engine |
| periph_irq_i | input | NUM_CH | Normal peripheral interrupt lines |
| irq_ack_i | input | NUM_CH | Handler-entry acknowledge per vector |
| start_o | output | 1 | Start pulse to the engine |
| start_ch_o | output | $clog2(NUM_CH) | Channel being started |
| start_burst_o | output | 1 | Started channel uses burst |
| irq_o | output | NUM_CH | Interrupt vectors; NUM_CH-1 is the software vector |

## Verification
A stuck or lost enable bit or mask bit shows as a start missing, or as an extra start, one cycle after the request. A stale software pending bit shows as a second start right after the channel's done strobe. A wrong active bit shows as a repeated start while a request is held. Errors in the pending-interrupt state appear on `irq_o` one cycle after done or acknowledge. Gating errors appear on `irq_o` in the same cycle as the peripheral interrupt.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned DEF_NUM_CH = 8;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dma_setclr_reg.sv
module dma_setclr_reg #(
  parameter int unsigned W        = 8,
  parameter bit          SET_WINS = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;
  generate
    if (SET_WINS) begin : g_set
      assign d = (q_o & ~clr_i) | set_i;
    end else begin : g_clr
      assign d = (q_o | set_i) & ~clr_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/dma_lowest_arb.sv
module dma_lowest_arb #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign vld_o = |req_i;
  assign oh_o  = vld_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/dma_irq_route.sv
module dma_irq_route #(
  parameter int unsigned N     = 8,
  parameter int unsigned SW_CH = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] periph_irq_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] irq_o
);
  // done beats ack in the same cycle
  dma_setclr_reg #(.W(N), .SET_WINS(1'b1)) u_pend (
    .clk_i, .rst_ni, .set_i(done_i), .clr_i(ack_i), .q_o(pend_o)
  );

  for (genvar c = 0; c < N; c++) begin : g_vec
    if (c == SW_CH) begin : g_sw
      assign irq_o[c] = pend_o[c];
    end else begin : g_per
      assign irq_o[c] = pend_o[c] | (periph_irq_i[c] & ~en_i[c]);
    end
  end
endmodule

// File: rtl/dma_req_irq_ctrl.sv
module dma_req_irq_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  localparam int unsigned IW    = idx_w(NUM_CH),
  localparam int unsigned SW_CH = NUM_CH - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] en_set_i,
  input  logic [NUM_CH-1:0] en_clr_i,
  input  logic [NUM_CH-1:0] mask_set_i,
  input  logic [NUM_CH-1:0] mask_clr_i,
  input  logic [NUM_CH-1:0] sw_req_i,
  input  logic [NUM_CH-1:0] hw_single_i,
  input  logic [NUM_CH-1:0] hw_burst_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] periph_irq_i,
  input  logic [NUM_CH-1:0] irq_ack_i,
  output logic              start_o,
  output logic [IW-1:0]     start_ch_o,
  output logic              start_burst_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] en_q, mask_q, sw_pend_q, act_q, irq_pend;
  logic [NUM_CH-1:0] hw_ok, ready, gnt_oh;
  logic              gnt_vld;
  logic [IW-1:0]     gnt_idx;

  dma_setclr_reg #(.W(NUM_CH), .SET_WINS(1'b0)) u_en (
    .clk_i, .rst_ni, .set_i(en_set_i), .clr_i(en_clr_i), .q_o(en_q)
  );
  dma_setclr_reg #(.W(NUM_CH), .SET_WINS(1'b1)) u_mask (
    .clk_i, .rst_ni, .set_i(mask_set_i), .clr_i(mask_clr_i), .q_o(mask_q)
  );
  // a new strobe in the grant cycle stays pending
  dma_setclr_reg #(.W(NUM_CH), .SET_WINS(1'b1)) u_swp (
    .clk_i, .rst_ni, .set_i(sw_req_i), .clr_i(gnt_oh), .q_o(sw_pend_q)
  );
  dma_setclr_reg #(.W(NUM_CH), .SET_WINS(1'b0)) u_act (
    .clk_i, .rst_ni, .set_i(gnt_oh), .clr_i(done_i), .q_o(act_q)
  );

  assign hw_ok = ~mask_q & (hw_single_i | hw_burst_i);
  assign ready = en_q & ~act_q & (sw_pend_q | hw_ok);

  dma_lowest_arb #(.N(NUM_CH), .IW(IW)) u_arb (
    .req_i(ready), .vld_o(gnt_vld), .idx_o(gnt_idx), .oh_o(gnt_oh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o       <= 1'b0;
      start_ch_o    <= '0;
      start_burst_o <= 1'b0;
    end else begin
      start_o       <= gnt_vld;
      start_ch_o    <= gnt_idx;
      start_burst_o <= gnt_vld & hw_burst_i[gnt_idx] & ~mask_q[gnt_idx];
    end
  end

  dma_irq_route #(.N(NUM_CH), .SW_CH(SW_CH)) u_irq (
    .clk_i, .rst_ni, .done_i, .ack_i(irq_ack_i), .periph_irq_i,
    .en_i(en_q), .pend_o(irq_pend), .irq_o
  );
endmodule

// File: rtl/dma_req_irq_chk.sv
module dma_req_irq_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IW     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_o,
  input logic [IW-1:0]     start_ch_o,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] act_q,
  input logic [NUM_CH-1:0] ready,
  input logic [NUM_CH-1:0] irq_pend,
  input logic [NUM_CH-1:0] done_i,
  input logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] en_d, act_d, rdy_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d <= '0; act_d <= '0; rdy_d <= '0;
    end else begin
      en_d <= en_q; act_d <= act_q; rdy_d <= ready;
    end
  end

  p_start_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> en_d[start_ch_o]);
  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !act_d[start_ch_o]);
  p_lowest_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ((rdy_d & ((NUM_CH'(1) << start_ch_o) - NUM_CH'(1))) == '0));
  p_done_raises_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & $past(done_i)) == $past(done_i)));
  p_gate_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & en_q & ~irq_pend) == '0);
endmodule

bind dma_req_irq_ctrl dma_req_irq_chk #(.NUM_CH(NUM_CH), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_o(start_o), .start_ch_o(start_ch_o),
  .en_q(en_q), .act_q(act_q), .ready(ready), .irq_pend(irq_pend),
  .done_i(done_i), .irq_o(irq_o)
);

// File: tb/dma_req_irq_ctrl_test.sv
module dma_req_irq_ctrl_test;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] en_set_i = '0, en_clr_i = '0, mask_set_i = '0, mask_clr_i = '0;
  logic [N-1:0] sw_req_i = '0, hw_single_i = '0, hw_burst_i = '0, done_i = '0;
  logic [N-1:0] periph_irq_i = '0, irq_ack_i = '0, irq_o;
  logic start_o, start_burst_o;
  logic [IW-1:0] start_ch_o;

  always #4 clk = ~clk;

  dma_req_irq_ctrl #(.NUM_CH(N)) uut (
    .clk_i(clk), .rst_ni, .en_set_i, .en_clr_i, .mask_set_i, .mask_clr_i,
    .sw_req_i, .hw_single_i, .hw_burst_i, .done_i, .periph_irq_i, .irq_ack_i,
    .start_o, .start_ch_o, .start_burst_o, .irq_o
  );

  int checks = 0, errors = 0, cyc = 0;
  typedef struct { int cyc; int ch; bit burst; } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int c, int ch, bit b);
    exp_t e;
    e.cyc = c; e.ch = ch; e.burst = b;
    q.push_back(e);
  endtask

  // monitor: compare starts against the scoreboard
  always @(posedge clk) begin
    cyc = cyc + 1;
    #2;
    if (q.size() > 0 && q[0].cyc < cyc) begin
      chk(0, "missed start", 0, q[0].ch);
      void'(q.pop_front());
    end
    if (q.size() > 0 && q[0].cyc == cyc) begin
      chk(start_o && int'(start_ch_o) == q[0].ch && start_burst_o == q[0].burst,
          "start R5/R6", {start_o, start_burst_o, 5'(start_ch_o)},
          {1'b1, q[0].burst, 5'(q[0].ch)});
      void'(q.pop_front());
    end else if (start_o && rst_ni) begin
      chk(0, "unexpected start R2/R3/R4/R7", int'(start_ch_o), -1);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic no_start(int n, string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(!start_o, tag, start_o, 0);
    end
  endtask

  task automatic irq_is(logic [N-1:0] e, string tag);
    chk(irq_o === e, tag, irq_o, e);
  endtask

  task automatic pulse_done(logic [N-1:0] m);
    done_i = m; tick(); done_i = '0;
  endtask

  task automatic pulse_ack(logic [N-1:0] m);
    irq_ack_i = m; tick(); irq_ack_i = '0;
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    periph_irq_i = '1;
    repeat (3) tick();
    irq_is(8'h7f, "R1 reset irq passthrough");
    chk(!start_o, "R1 reset start", start_o, 0);
    periph_irq_i = '0;
    rst_ni = 1'b1;
    tick();
    irq_is(8'h00, "R1 idle irq");

    // disabled channel ignores request
    hw_single_i[2] = 1'b1;
    no_start(3, "R2 disabled");

    // enable -> start two cycles after the strobe cycle
    en_set_i[2] = 1'b1; push(cyc + 2, 2, 0); tick(); en_set_i = '0;
    tick(); tick();
    no_start(3, "R7 held request no restart");
    hw_single_i = '0;
    pulse_done(8'h04);
    irq_is(8'h04, "R8 done on vector 2");
    pulse_ack(8'h04);
    irq_is(8'h00, "R9 ack clears");

    // gating of normal peripheral interrupts
    periph_irq_i = 8'h8c; #1;
    irq_is(8'h08, "R10 enabled gated, sw vector ignores");
    periph_irq_i = '0;

    // mask blocks hardware, not software
    mask_set_i[2] = 1'b1; tick(); mask_set_i = '0;
    hw_burst_i[2] = 1'b1;
    no_start(3, "R3 masked hw ignored");
    sw_req_i[2] = 1'b1; push(cyc + 2, 2, 0); tick(); sw_req_i = '0;
    tick(); tick();
    pulse_done(8'h04);
    irq_is(8'h04, "R8 sw-triggered peripheral on own vector");
    pulse_ack(8'h04);
    no_start(3, "R4 sw request self-cleared");

    // unmask with both requests: burst wins
    hw_single_i[2] = 1'b1;
    mask_clr_i[2] = 1'b1; push(cyc + 2, 2, 1); tick(); mask_clr_i = '0;
    tick(); tick();
    hw_single_i = '0; hw_burst_i = '0;
    pulse_done(8'h04); pulse_ack(8'h04);

    // two ready together: lowest first
    hw_single_i = 8'h30;
    en_set_i = 8'h30; push(cyc + 2, 4, 0); push(cyc + 3, 5, 0); tick(); en_set_i = '0;
    tick(); tick(); tick();
    hw_single_i = '0;
    pulse_done(8'h30);
    irq_is(8'h30, "R8 both vectors pending");
    pulse_ack(8'h30);
    irq_is(8'h00, "R9 both cleared");

    // software channel
    en_set_i[7] = 1'b1; sw_req_i[7] = 1'b1; push(cyc + 2, 7, 0); tick();
    en_set_i = '0; sw_req_i = '0;
    tick(); tick();
    pulse_done(8'h80);
    irq_is(8'h80, "R8 software vector");
    no_start(3, "R4 sw channel no repeat");
    done_i = 8'h80; irq_ack_i = 8'h80; tick(); done_i = '0; irq_ack_i = '0;
    irq_is(8'h80, "R9 done wins over ack");
    pulse_ack(8'h80);
    irq_is(8'h00, "R9 cleared");

    // disable: interrupts pass again, requests ignored
    en_set_i[2] = 1'b1; en_clr_i[2] = 1'b1; tick(); en_set_i = '0; en_clr_i = '0;
    periph_irq_i = 8'h04; #1;
    irq_is(8'h04, "R2 clear wins / R10 passthrough");
    hw_single_i[2] = 1'b1;
    no_start(3, "R2 disabled again");
    hw_single_i = '0; periph_irq_i = '0;

    repeat (3) tick();
    chk(q.size() == 0, "scoreboard drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule